// File: doc/BRIEF.md
# Sequential-Pattern SRAM Self-Tester

This block sits between a memory controller's request port and the logic that normally uses it. When a test is started, it disconnects the normal user from the memory port and runs two passes over every location of the memory. The first pass stores into each location the low data-width bits of that location's own address. The second pass begins only after the last location has been written, and it reads every location back, comparing each value with the low bits of the address. Because all writes are complete before the first read, a data bus that merely keeps the last value driven onto it cannot look like a working memory.

Each access is a request/acknowledge exchange. The tester holds its request, address, direction and write data steady until the controller acknowledges, and only then moves to the next location. The first mismatch ends the test at once. The failing address and the data read from it are held until the next start. If every location matches, the pass flag is raised. While no test is running, user requests and acknowledges pass straight through.

Top module: `mem_sweep_tester`

## Requirements
- R1: After reset, busy, pass and fail are 0, the captured failing address and data are 0, and the memory port carries the user's request.
- R2: While busy is 0, the user's request, direction, address and write data reach the memory port unchanged, and the memory's acknowledge and read data return to the user.
- R3: While busy is 1, the user receives no acknowledge and none of its requests reach the memory port.
- R4: A start seen while idle sets busy on the next cycle. The write pass then issues writes (direction 1) to addresses 0, 1, 2 … 2^ADDR_W-1 in ascending order, each carrying the value address mod 2^DATA_W.
- R5: The read pass begins only after the write to the last address is acknowledged. It issues reads (direction 0) starting again at address 0 and ascending one location per acknowledge.
- R6: While a request is held without an acknowledge, its address, direction and write data stay unchanged. Exactly one access advances per acknowledge.
- R7: A read value that differs from address mod 2^DATA_W ends the test at that access: fail becomes 1, busy becomes 0, and no further request is issued.
- R8: On a failure, the address of the failing location and the data read from it are captured and held, unchanged by later user traffic, until the next start.
- R9: When the last address is read and matches, pass becomes 1 and busy becomes 0. Pass and fail are never 1 together.
- R10: A start while busy is ignored and the running pass continues undisturbed. A start from idle clears pass, fail and the captured address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a test when idle |
| busy | output | 1 | Test in progress; tester owns the memory port |
| pass | output | 1 | Last test matched at every location |
| fail | output | 1 | Last test found a mismatch |
| fail_addr | output | ADDR_W | Address of the first failing location |
| fail_data | output | DATA_W | Data read at the failing location |
| usr_req | input | 1 | User request |
| usr_we | input | 1 | User direction, 1 = write |
| usr_addr | input | ADDR_W | User address |
| usr_wdata | input | DATA_W | User write data |
| usr_ack | output | 1 | Acknowledge returned to the user |
| usr_rdata | output | DATA_W | Read data returned to the user |
| mem_req | output | 1 | Request toward the memory controller |
| mem_we | output | 1 | Direction toward the controller, 1 = write |
| mem_addr | output | ADDR_W | Address toward the controller |
| mem_wdata | output | DATA_W | Write data toward the controller |
| mem_ack | input | 1 | Acknowledge from the controller |
| mem_rdata | input | DATA_W | Read data from the controller |

## Verification
The tester is run against a 512-location memory model, so the written pattern wraps past 256. The model is healthy in some runs. In other runs it has an address line that aliases two locations, a data bit stuck low, a bus that returns only the last value driven, or a single corrupted cell above the wrap point. Each fault yields a different first failing address and read value, which checks both the early stop and the captured values. Acknowledge latencies of zero, one and three cycles confirm that requests are held steady until acknowledged. User traffic and extra start pulses applied during a test confirm that the port is isolated and that a second start has no effect.

// File: rtl/mst_pkg.sv
package mst_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2
  } mst_state_e;

  // Value stored at a location: its address reduced modulo 2^dw.
  function automatic logic [31:0] fill_value(input logic [31:0] a, input int dw);
    logic [31:0] mask;
    mask = (dw >= 32) ? 32'hFFFF_FFFF : ((32'h1 << dw) - 32'h1);
    return a & mask;
  endfunction

endpackage

// File: rtl/mst_addr_counter.sv
module mst_addr_counter #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr,
  output logic              at_last
);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n)   addr <= '0;
    else if (clr) addr <= '0;
    else if (inc) addr <= addr + 1'b1;
  end

  assign at_last = (addr == LAST);

  // R5
  clear_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (addr == '0));

  // R6
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |=> (addr == $past(addr) + 1'b1));

endmodule

// File: rtl/mst_sequencer.sv
module mst_sequencer
  import mst_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic              at_last,
  input  logic              ack,
  input  logic [DATA_W-1:0] rdata,
  output logic              req,
  output logic              we,
  output logic [DATA_W-1:0] wdata,
  output logic              cnt_clr,
  output logic              cnt_inc,
  output logic              busy,
  output logic              pass,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_data
);
  mst_state_e state, state_nx;

  logic [DATA_W-1:0] expect_val;
  logic acc_done, rd_match, start_go;
  logic ev_phase_flip, ev_mismatch, ev_all_ok;

  assign expect_val    = DATA_W'(fill_value(32'(addr), DATA_W));
  assign acc_done      = (state != ST_IDLE) && ack;
  assign rd_match      = (rdata == expect_val);
  assign start_go      = (state == ST_IDLE) && start;
  assign ev_phase_flip = (state == ST_WRITE) && acc_done && at_last;
  assign ev_mismatch   = (state == ST_READ) && acc_done && !rd_match;
  assign ev_all_ok     = (state == ST_READ) && acc_done && rd_match && at_last;

  assign cnt_clr = start_go || ev_phase_flip;
  assign cnt_inc = acc_done && !ev_phase_flip && !ev_mismatch && !ev_all_ok;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (start) state_nx = ST_WRITE;
      ST_WRITE: if (ev_phase_flip) state_nx = ST_READ;
      ST_READ:  if (ev_mismatch || ev_all_ok) state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      pass      <= 1'b0;
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_data <= '0;
    end else begin
      state <= state_nx;
      if (start_go) begin
        pass      <= 1'b0;
        fail      <= 1'b0;
        fail_addr <= '0;
        fail_data <= '0;
      end
      if (ev_mismatch) begin
        fail      <= 1'b1;
        fail_addr <= addr;
        fail_data <= rdata;
      end
      if (ev_all_ok) pass <= 1'b1;
    end
  end

  assign busy  = (state != ST_IDLE);
  assign req   = busy;
  assign we    = (state == ST_WRITE);
  assign wdata = expect_val;

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> (req && $stable(addr) && $stable(we)));

  // R7
  stop_on_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mismatch |=> (!req && fail));

  // R9
  pass_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail));

  // R5
  read_after_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_phase_flip |=> (req && !we));

  // R8
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(fail_addr) && $stable(fail_data)));

endmodule

// File: rtl/mst_port_mux.sv
module mst_port_mux #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              sel_tst,
  input  logic              tst_req,
  input  logic              tst_we,
  input  logic [ADDR_W-1:0] tst_addr,
  input  logic [DATA_W-1:0] tst_wdata,
  output logic              tst_ack,
  input  logic              usr_req,
  input  logic              usr_we,
  input  logic [ADDR_W-1:0] usr_addr,
  input  logic [DATA_W-1:0] usr_wdata,
  output logic              usr_ack,
  output logic [DATA_W-1:0] usr_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  always_comb begin
    if (sel_tst) begin
      mem_req   = tst_req;
      mem_we    = tst_we;
      mem_addr  = tst_addr;
      mem_wdata = tst_wdata;
    end else begin
      mem_req   = usr_req;
      mem_we    = usr_we;
      mem_addr  = usr_addr;
      mem_wdata = usr_wdata;
    end
  end

  assign tst_ack   = sel_tst & mem_ack;
  assign usr_ack   = ~sel_tst & mem_ack;
  assign usr_rdata = mem_rdata;

endmodule

// File: rtl/mem_sweep_tester.sv
module mem_sweep_tester #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              pass,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_data,
  input  logic              usr_req,
  input  logic              usr_we,
  input  logic [ADDR_W-1:0] usr_addr,
  input  logic [DATA_W-1:0] usr_wdata,
  output logic              usr_ack,
  output logic [DATA_W-1:0] usr_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic [ADDR_W-1:0] cnt_addr;
  logic              cnt_last, cnt_clr, cnt_inc;
  logic              tst_req, tst_we, tst_ack;
  logic [DATA_W-1:0] tst_wdata;

  mst_addr_counter #(.ADDR_W(ADDR_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc),
    .addr(cnt_addr), .at_last(cnt_last)
  );

  mst_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .addr(cnt_addr), .at_last(cnt_last),
    .ack(tst_ack), .rdata(mem_rdata),
    .req(tst_req), .we(tst_we), .wdata(tst_wdata),
    .cnt_clr(cnt_clr), .cnt_inc(cnt_inc),
    .busy(busy), .pass(pass), .fail(fail),
    .fail_addr(fail_addr), .fail_data(fail_data)
  );

  mst_port_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .sel_tst(busy),
    .tst_req(tst_req), .tst_we(tst_we), .tst_addr(cnt_addr),
    .tst_wdata(tst_wdata), .tst_ack(tst_ack),
    .usr_req(usr_req), .usr_we(usr_we), .usr_addr(usr_addr),
    .usr_wdata(usr_wdata), .usr_ack(usr_ack), .usr_rdata(usr_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // R3
  user_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !usr_ack);

  // R10
  start_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !mem_ack) |=> busy);

endmodule

// File: tb/mem_sweep_tester_tb.sv
module mem_sweep_tester_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 9;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, pass, fail;
  logic [AW-1:0] fail_addr;
  logic [DW-1:0] fail_data;
  logic usr_req = 1'b0, usr_we = 1'b0;
  logic [AW-1:0] usr_addr = '0;
  logic [DW-1:0] usr_wdata = '0;
  logic usr_ack;
  logic [DW-1:0] usr_rdata;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  int checks = 0, errors = 0, cycles = 0;
  int fault = 0, lat = 0, lat_cnt = 0;
  int mon_idx = 0;
  bit mon_on = 0, wd_hit = 0;
  logic [DW-1:0] cells [DEPTH];
  logic [DW-1:0] last_bus = '0;
  logic prev_pend = 0, prev_we = 0;
  logic [AW-1:0] prev_addr = '0;
  logic [DW-1:0] prev_wdata = '0;

  mem_sweep_tester #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .pass(pass), .fail(fail),
    .fail_addr(fail_addr), .fail_data(fail_data),
    .usr_req(usr_req), .usr_we(usr_we), .usr_addr(usr_addr),
    .usr_wdata(usr_wdata), .usr_ack(usr_ack), .usr_rdata(usr_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int cell_of(input int a);
    return (fault == 1) ? (a & ~4) : a;
  endfunction

  // Memory model with configurable latency and injected faults.
  always @(posedge clk) begin
    cycles <= cycles + 1;
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      if (lat_cnt >= lat) begin
        lat_cnt <= 0;
        mem_ack <= 1'b1;
        if (mem_we) begin
          cells[cell_of(int'(mem_addr))] <= (fault == 2) ? (mem_wdata & 8'hF7) : mem_wdata;
          last_bus <= mem_wdata;
        end else begin
          if (fault == 3) mem_rdata <= last_bus;
          else if (fault == 4 && mem_addr == AW'(300))
            mem_rdata <= cells[cell_of(int'(mem_addr))] ^ 8'h01;
          else mem_rdata <= cells[cell_of(int'(mem_addr))];
        end
      end else lat_cnt <= lat_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Access monitor: order, values and handshake stability.
  always @(negedge clk) begin
    if (mon_on && busy) begin
      chk(!usr_ack, "R3 user ack while busy", int'(usr_ack), 0);
      if (prev_pend)
        chk(mem_addr == prev_addr && mem_we == prev_we && mem_wdata == prev_wdata,
            "R6 request changed before ack", int'(mem_addr), int'(prev_addr));
    end
    if (mon_on && mem_req && mem_ack) begin
      if (mon_idx < DEPTH) begin
        chk(mem_we == 1'b1 && int'(mem_addr) == mon_idx, "R4 write order",
            int'(mem_addr), mon_idx);
        chk(int'(mem_wdata) == (mon_idx % 256), "R4 write value",
            int'(mem_wdata), mon_idx % 256);
      end else begin
        chk(mem_we == 1'b0 && int'(mem_addr) == mon_idx - DEPTH, "R5 read order",
            int'(mem_addr), mon_idx - DEPTH);
      end
      mon_idx = mon_idx + 1;
    end
    prev_pend  = mon_on && mem_req && !mem_ack;
    prev_addr  = mem_addr;
    prev_we    = mem_we;
    prev_wdata = mem_wdata;
  end

  always @(negedge clk) begin
    if (cycles > WD_LIMIT && !wd_hit) begin
      wd_hit = 1;
      chk(0, "watchdog expired", cycles, WD_LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic user_access(input bit w, input int a, input int d, output int rd);
    usr_req = 1'b1; usr_we = w; usr_addr = AW'(a); usr_wdata = DW'(d);
    @(negedge clk);
    while (!usr_ack) @(negedge clk);
    rd = int'(usr_rdata);
    usr_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_test(input int f, input int l, input bit exp_pass,
                          input int exp_fa, input int exp_fd, input bit poke);
    fault = f; lat = l; mon_idx = 0; mon_on = 1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !pass && !fail && fail_addr == '0, "R10 start clears flags / R4 busy",
        int'({busy, pass, fail}), 4);
    if (poke) begin
      repeat (20) @(negedge clk);
      usr_req = 1'b1; usr_we = 1'b1; usr_addr = AW'(77); usr_wdata = 8'hA5;
      start = 1'b1;
      repeat (4) @(negedge clk);
      start = 1'b0;
      repeat (10) @(negedge clk);
      usr_req = 1'b0;
    end
    while (busy) @(negedge clk);
    mon_on = 0;
    if (exp_pass) begin
      chk(pass && !fail, "R9 pass reported", int'({pass, fail}), 2);
      chk(mon_idx == 2 * DEPTH, "R5 full read pass", mon_idx, 2 * DEPTH);
    end else begin
      chk(fail && !pass, "R7 fail reported", int'({pass, fail}), 1);
      chk(int'(fail_addr) == exp_fa, "R8 failing address", int'(fail_addr), exp_fa);
      chk(int'(fail_data) == exp_fd, "R8 failing data", int'(fail_data), exp_fd);
      chk(mon_idx == DEPTH + exp_fa + 1, "R7 stopped at mismatch", mon_idx, DEPTH + exp_fa + 1);
      begin
        int seen = 0;
        int rd;
        for (int k = 0; k < 6; k++) begin
          @(negedge clk);
          if (mem_req) seen++;
        end
        chk(seen == 0, "R7 no request after fail", seen, 0);
        fault = 0;
        user_access(1'b1, 9, 200, rd);
        chk(int'(fail_addr) == exp_fa && int'(fail_data) == exp_fd, "R8 capture held",
            int'(fail_addr), exp_fa);
      end
    end
  endtask

  initial begin
    int rd;
    for (int i = 0; i < DEPTH; i++) cells[i] = 8'h5A;
    repeat (3) @(negedge clk);
    chk(!busy && !pass && !fail, "R1 reset flags", int'({busy, pass, fail}), 0);
    chk(fail_addr == '0 && fail_data == '0, "R1 reset capture", int'(fail_addr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    usr_req = 1'b1; usr_addr = AW'(5);
    #1;
    chk(mem_req && mem_addr == AW'(5), "R1 user owns port after reset", int'(mem_addr), 5);
    usr_req = 1'b0;
    @(negedge clk);
    user_access(1'b1, 123, 8'h3C, rd);
    user_access(1'b0, 123, 0, rd);
    chk(rd == 8'h3C, "R2 user pass-through readback", rd, 8'h3C);
    user_access(1'b1, 400, 8'hC3, rd);
    user_access(1'b0, 400, 0, rd);
    chk(rd == 8'hC3, "R2 user pass-through second", rd, 8'hC3);

    run_test(0, 0, 1, 0, 0, 0);
    run_test(0, 1, 1, 0, 0, 1);
    user_access(1'b0, 77, 0, rd);
    chk(rd == 77, "R3 user write blocked during test", rd, 77);
    run_test(0, 3, 1, 0, 0, 0);
    run_test(1, 1, 0, 0, 4, 0);
    run_test(2, 0, 0, 8, 0, 0);
    run_test(3, 2, 0, 0, 8'hFF, 0);
    run_test(4, 0, 0, 300, 45, 0);
    run_test(0, 0, 1, 0, 0, 0);
    chk(fail_addr == '0 && fail_data == '0, "R10 capture cleared by start", int'(fail_addr), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule